// File: doc/BRIEF.md
# Packed SIMD Saturating Adder

This block adds two 32-bit operand words in one of three element layouts: a single 32-bit value, two independent 16-bit halves or four independent 8-bit bytes. One byte-segmented adder serves every layout. The carry path between byte segments is broken wherever a field ends, so each element is summed on its own and written back into the same field of the result word.

Each element width has a signed and an unsigned form and two overflow behaviours. In wrap mode the result is plain two's-complement and is taken modulo the field width. In saturating mode an overflowing field is clamped to the largest value its type can hold, and an underflowing field to the smallest. When a full 32-bit value is added in wrap mode, the carry out of the top bit is also returned as a separate 32-bit carry word. Both outputs are registered, so results appear one clock after the operands.

Top module: `simd_sat_adder`

## Requirements
- R1: The `elem_w` code selects the element layout: 2'b00 is four bytes (byte k in bits 8k+7:8k), 2'b01 is two halves (half k in bits 16k+15:16k), and 2'b10 and 2'b11 both mean one 32-bit word. `is_signed`=1 selects signed elements and `sat_en`=1 selects saturating mode.
- R2: With `sat_en`=0, each field of `sum_o` equals (field of a + field of b) modulo 2^width. No carry passes from one field into the next.
- R3: With `sat_en`=1 and `is_signed`=0, a field whose unsigned sum exceeds the field maximum becomes all ones. Any other field holds the exact sum. For example, in half mode 0xFFFE + 0x0003 gives 0xFFFF, while the same inputs in wrap mode give 0x0001.
- R4: With `sat_en`=1 and `is_signed`=1, a field overflows when both inputs have the same sign and the sum's sign differs. A positive overflow gives 0x7F, 0x7FFF or 0x7FFFFFFF. A negative overflow gives 0x80, 0x8000 or 0x80000000. Any other field holds the exact sum.
- R5: With `sat_en`=0, `is_signed` has no effect on `sum_o`.
- R6: In word layout with `sat_en`=0, bit 0 of `carry_o` is the carry out of the unsigned 32-bit addition and bits 31:1 are zero.
- R7: In every other mode (packed layout or `sat_en`=1), `carry_o` is zero, even when a field overflows.
- R8: `sum_o` and `carry_o` are registered. They show the result of the operands present at the previous rising clock edge. While `rst_n` is low both are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| opnd_a | input | 32 | First packed operand |
| opnd_b | input | 32 | Second packed operand |
| elem_w | input | 2 | Element layout code |
| is_signed | input | 1 | Signed elements when 1 |
| sat_en | input | 1 | Saturating mode when 1 |
| sum_o | output | 32 | Packed sum, one cycle after the operands |
| carry_o | output | 32 | Carry word, bit 0 meaningful only in word wrap mode |

## Verification
Operands with all-ones low fields plus one are added in each layout. This separates a correct carry cut at the byte and half boundaries from a carry that leaks into the neighbouring field, and it confirms that the full-word carry reaches `carry_o`. Values at the signed limits are added in both orders and with mixed signs. This tells a genuine overflow apart from a large sum that must not be clamped, and it shows which clamp value each sign receives. The same operands are replayed with the signedness and saturation controls toggled, so that any effect of signedness in wrap mode and any carry word outside word wrap mode become visible. A pseudo-random sweep across all mode codes then compares every result with an arithmetic model of each field.

// File: rtl/simd_sat_pkg.sv
package simd_sat_pkg;

    // Element layout codes on the elem_w port
    typedef enum logic [1:0] {
        EW_BYTE     = 2'b00,
        EW_HALF     = 2'b01,
        EW_WORD     = 2'b10,
        EW_WORD_ALT = 2'b11
    } elem_w_e;

endpackage

// File: rtl/simd_seg_adder.sv
// Byte-segmented adder: one carry-propagate chain whose links between
// segments can be opened to isolate packed fields.
module simd_seg_adder #(
    parameter int unsigned DATA_W = 32,
    parameter int unsigned SEG_W  = 8,
    localparam int unsigned NSEG  = DATA_W / SEG_W
) (
    input  logic [DATA_W-1:0] a,
    input  logic [DATA_W-1:0] b,
    input  logic [NSEG-1:0]   link,     // link[i]: carry from segment i-1 enters segment i
    output logic [DATA_W-1:0] raw_sum,
    output logic [NSEG-1:0]   seg_cout
);

    logic [NSEG-1:0] seg_cin;

    for (genvar i = 0; i < NSEG; i++) begin : g_seg
        if (i == 0) begin : g_first
            assign seg_cin[i] = 1'b0;
        end else begin : g_rest
            assign seg_cin[i] = link[i] & seg_cout[i-1];
        end

        logic [SEG_W:0] part_d;

        always_comb begin
            part_d = {1'b0, a[i*SEG_W +: SEG_W]}
                   + {1'b0, b[i*SEG_W +: SEG_W]}
                   + {{SEG_W{1'b0}}, seg_cin[i]};
        end

        assign raw_sum[i*SEG_W +: SEG_W] = part_d[SEG_W-1:0];
        assign seg_cout[i]               = part_d[SEG_W];
    end

    // link[0] has no segment below it
    logic unused_link0;
    assign unused_link0 = link[0];

endmodule

// File: rtl/simd_sat_clamp.sv
// Per-segment result selection. The overflow decision is made at the top
// segment of each field and applied to every segment of that field.
module simd_sat_clamp #(
    parameter int unsigned DATA_W = 32,
    parameter int unsigned SEG_W  = 8,
    localparam int unsigned NSEG  = DATA_W / SEG_W,
    localparam int unsigned IDX_W = $clog2(NSEG)
) (
    input  logic [DATA_W-1:0] a,
    input  logic [DATA_W-1:0] b,
    input  logic [DATA_W-1:0] raw_sum,
    input  logic [NSEG-1:0]   seg_cout,
    input  logic [IDX_W-1:0]  field_mask,  // segments per field minus one
    input  logic              is_signed,
    input  logic              sat_en,
    output logic [DATA_W-1:0] sum
);

    logic [SEG_W-1:0] a_s [NSEG];
    logic [SEG_W-1:0] b_s [NSEG];
    logic [SEG_W-1:0] r_s [NSEG];

    for (genvar k = 0; k < NSEG; k++) begin : g_split
        assign a_s[k] = a[k*SEG_W +: SEG_W];
        assign b_s[k] = b[k*SEG_W +: SEG_W];
        assign r_s[k] = raw_sum[k*SEG_W +: SEG_W];
    end

    for (genvar j = 0; j < NSEG; j++) begin : g_clamp
        localparam logic [IDX_W-1:0] SELF_IDX = IDX_W'(j);

        logic [IDX_W-1:0] top_idx;
        logic             a_msb;
        logic             b_msb;
        logic             r_msb;
        logic             ovf_u;
        logic             ovf_s;
        logic             is_top;
        logic [SEG_W-1:0] seg_d;

        always_comb begin
            top_idx = SELF_IDX | field_mask;
            is_top  = (top_idx == SELF_IDX);
            a_msb   = a_s[top_idx][SEG_W-1];
            b_msb   = b_s[top_idx][SEG_W-1];
            r_msb   = r_s[top_idx][SEG_W-1];
            ovf_u   = seg_cout[top_idx];
            ovf_s   = (a_msb == b_msb) && (r_msb != a_msb);

            seg_d = r_s[j];
            if (sat_en) begin
                if (is_signed && ovf_s) begin
                    if (!a_msb) begin
                        // positive overflow: 0111..1 across the field
                        seg_d = {~is_top, {(SEG_W-1){1'b1}}};
                    end else begin
                        // negative overflow: 1000..0 across the field
                        seg_d = {is_top, {(SEG_W-1){1'b0}}};
                    end
                end else if (!is_signed && ovf_u) begin
                    seg_d = {SEG_W{1'b1}};
                end
            end
        end

        assign sum[j*SEG_W +: SEG_W] = seg_d;
    end

endmodule

// File: rtl/simd_sat_adder.sv
module simd_sat_adder #(
    parameter int unsigned DATA_W = 32,
    parameter int unsigned SEG_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] opnd_a,
    input  logic [DATA_W-1:0] opnd_b,
    input  logic [1:0]        elem_w,
    input  logic              is_signed,
    input  logic              sat_en,
    output logic [DATA_W-1:0] sum_o,
    output logic [DATA_W-1:0] carry_o
);
    import simd_sat_pkg::*;

    localparam int unsigned NSEG      = DATA_W / SEG_W;
    localparam int unsigned IDX_W     = $clog2(NSEG);
    localparam int unsigned HALF_SEGS = (DATA_W / 2) / SEG_W;

    typedef struct packed {
        logic [DATA_W-1:0] sum;
        logic [DATA_W-1:0] carry;
        logic              warm;
    } out_state_s;

    out_state_s nxt_d, cur_q;

    elem_w_e          mode;
    logic [IDX_W-1:0] field_mask;
    logic             word_mode;
    logic [NSEG-1:0]  link;
    logic [DATA_W-1:0] raw_sum;
    logic [NSEG-1:0]   seg_cout;
    logic [DATA_W-1:0] clamp_sum;

    // layout decode: how many segments make up one field
    always_comb begin
        mode = elem_w_e'(elem_w);
        word_mode = 1'b0;
        unique case (mode)
            EW_BYTE: field_mask = '0;
            EW_HALF: field_mask = IDX_W'(HALF_SEGS - 1);
            default: begin
                field_mask = '1;
                word_mode  = 1'b1;
            end
        endcase
    end

    for (genvar i = 0; i < NSEG; i++) begin : g_link
        assign link[i] = |(IDX_W'(i) & field_mask);
    end

    simd_seg_adder #(.DATA_W(DATA_W), .SEG_W(SEG_W)) u_adder (
        .a        (opnd_a),
        .b        (opnd_b),
        .link     (link),
        .raw_sum  (raw_sum),
        .seg_cout (seg_cout)
    );

    simd_sat_clamp #(.DATA_W(DATA_W), .SEG_W(SEG_W)) u_clamp (
        .a          (opnd_a),
        .b          (opnd_b),
        .raw_sum    (raw_sum),
        .seg_cout   (seg_cout),
        .field_mask (field_mask),
        .is_signed  (is_signed),
        .sat_en     (sat_en),
        .sum        (clamp_sum)
    );

    always_comb begin
        nxt_d       = cur_q;
        nxt_d.sum   = clamp_sum;
        nxt_d.carry = '0;
        if (word_mode && !sat_en) begin
            nxt_d.carry[0] = seg_cout[NSEG-1];
        end
        nxt_d.warm  = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_q <= '0;
        end else begin
            cur_q <= nxt_d;
        end
    end

    assign sum_o   = cur_q.sum;
    assign carry_o = cur_q.carry;

    // ------------------------------------------------------------------
    // Assertions
    // ------------------------------------------------------------------
    logic [DATA_W:0] chk_full_w;
    assign chk_full_w = {1'b0, opnd_a} + {1'b0, opnd_b};

    // R2
    word_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_q.warm && $past(elem_w[1] && !sat_en))
        |-> (sum_o == $past(chk_full_w[DATA_W-1:0])));

    // R6
    carry_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_q.warm && $past(elem_w[1] && !sat_en))
        |-> (carry_o == {{(DATA_W-1){1'b0}}, $past(chk_full_w[DATA_W])}));

    // R7
    carry_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_q.warm && $past(!(elem_w[1] && !sat_en)))
        |-> (carry_o == '0));

    for (genvar s = 0; s < NSEG; s++) begin : g_floor_chk
        // R3
        usat_floor_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (cur_q.warm && $past(sat_en && !is_signed && (elem_w == 2'b00)))
            |-> (sum_o[s*SEG_W +: SEG_W] >= $past(opnd_a[s*SEG_W +: SEG_W])));
    end

endmodule

// File: tb/simd_sat_adder_bench.sv
`timescale 1ns/1ps
module simd_sat_adder_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] opnd_a = '0;
    logic [31:0] opnd_b = '0;
    logic [1:0]  elem_w = 2'b00;
    logic        is_signed = 1'b0;
    logic        sat_en = 1'b0;
    logic [31:0] sum_o;
    logic [31:0] carry_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;   // 50 MHz

    simd_sat_adder u_simd_sat_adder (
        .clk       (clk),
        .rst_n     (rst_n),
        .opnd_a    (opnd_a),
        .opnd_b    (opnd_b),
        .elem_w    (elem_w),
        .is_signed (is_signed),
        .sat_en    (sat_en),
        .sum_o     (sum_o),
        .carry_o   (carry_o)
    );

    // Arithmetic model built from the requirements: returns {carry, sum}
    function automatic logic [63:0] model(input logic [31:0] a, input logic [31:0] b,
                                          input logic [1:0] ew, input logic sg, input logic sat);
        int fw;
        longint mask, ua, ub, us, sa, sb, ss, hi, lo, r;
        logic [31:0] s_acc, c_acc;
        fw = (ew == 2'b00) ? 8 : (ew == 2'b01) ? 16 : 32;
        mask = (64'sd1 <<< fw) - 1;
        s_acc = '0;
        c_acc = '0;
        for (int k = 0; k < 32 / fw; k++) begin
            ua = (longint'({32'd0, a}) >>> (k * fw)) & mask;
            ub = (longint'({32'd0, b}) >>> (k * fw)) & mask;
            us = ua + ub;
            r  = us & mask;
            if (sat && !sg) begin
                if (us > mask) r = mask;
            end else if (sat && sg) begin
                sa = ua[fw-1] ? ua - (mask + 1) : ua;
                sb = ub[fw-1] ? ub - (mask + 1) : ub;
                ss = sa + sb;
                hi = (64'sd1 <<< (fw - 1)) - 1;
                lo = -(64'sd1 <<< (fw - 1));
                if (ss > hi) ss = hi;
                if (ss < lo) ss = lo;
                r = ss & mask;
            end
            s_acc = s_acc | (32'(r) << (k * fw));
            if (fw == 32 && !sat) c_acc = {31'd0, us[32]};
        end
        return {c_acc, s_acc};
    endfunction

    task automatic check(input string req, input string what,
                         input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s %s: got %h expected %h", req, what, got, exp);
        end
    endtask

    // drive at a falling edge, sample at the next falling edge
    task automatic apply(input logic [31:0] a, input logic [31:0] b,
                         input logic [1:0] ew, input logic sg, input logic sat);
        @(negedge clk);
        opnd_a = a; opnd_b = b; elem_w = ew; is_signed = sg; sat_en = sat;
        @(negedge clk);
    endtask

    task automatic run_vec(input string req, input logic [31:0] a, input logic [31:0] b,
                           input logic [1:0] ew, input logic sg, input logic sat);
        logic [63:0] m;
        apply(a, b, ew, sg, sat);
        m = model(a, b, ew, sg, sat);
        check(req, "sum", sum_o, m[31:0]);
        check(req, "carry", carry_o, m[63:32]);
    endtask

    task automatic t_reset();
        check("R8", "reset sum", sum_o, 32'h0);
        check("R8", "reset carry", carry_o, 32'h0);
    endtask

    task automatic t_wrap_layouts();
        apply(32'hFFFF_FFFF, 32'h0000_0001, 2'b10, 1'b0, 1'b0);
        check("R6", "word wrap sum", sum_o, 32'h0000_0000);
        check("R6", "word carry", carry_o, 32'h0000_0001);
        apply(32'h0000_FFFF, 32'h0000_0001, 2'b01, 1'b0, 1'b0);
        check("R2", "half cut at 16", sum_o, 32'h0000_0000);
        check("R7", "half carry zero", carry_o, 32'h0);
        apply(32'h01FF_80FF, 32'h0101_0101, 2'b00, 1'b0, 1'b0);
        check("R2", "byte cuts", sum_o, 32'h0200_8100);
        apply(32'h00FF_FFFF, 32'h0000_0001, 2'b01, 1'b0, 1'b0);
        check("R2", "half inner carry", sum_o, 32'h00FF_0000);
        apply(32'h0000_00FF, 32'h0000_0001, 2'b10, 1'b0, 1'b0);
        check("R2", "word full carry", sum_o, 32'h0000_0100);
    endtask

    task automatic t_mode_codes();
        apply(32'hFFFF_FFFF, 32'h0000_0002, 2'b11, 1'b0, 1'b0);
        check("R1", "code 11 is word sum", sum_o, 32'h0000_0001);
        check("R1", "code 11 is word carry", carry_o, 32'h0000_0001);
    endtask

    task automatic t_unsigned_sat();
        apply(32'h0000_FFFE, 32'h0000_0003, 2'b01, 1'b0, 1'b0);
        check("R3", "half wrap example", sum_o, 32'h0000_0001);
        apply(32'h0000_FFFE, 32'h0000_0003, 2'b01, 1'b0, 1'b1);
        check("R3", "half sat example", sum_o, 32'h0000_FFFF);
        check("R7", "sat mode carry zero", carry_o, 32'h0);
        apply(32'hF010_80FF, 32'h2020_7F01, 2'b00, 1'b0, 1'b1);
        check("R3", "byte sat mix", sum_o, 32'hFF30_FFFF);
        apply(32'hFFFF_FFFF, 32'h0000_0001, 2'b10, 1'b0, 1'b1);
        check("R3", "word sat", sum_o, 32'hFFFF_FFFF);
        check("R7", "word sat carry zero", carry_o, 32'h0);
    endtask

    task automatic t_signed_sat();
        apply(32'h7F80_407F, 32'h01FF_40F0, 2'b00, 1'b1, 1'b1);
        check("R4", "byte signed clamps", sum_o, 32'h7F80_7F6F);
        apply(32'h7FFF_8000, 32'h0001_FFFF, 2'b01, 1'b1, 1'b1);
        check("R4", "half signed clamps", sum_o, 32'h7FFF_8000);
        apply(32'h7FFF_FFFF, 32'h0000_0001, 2'b10, 1'b1, 1'b1);
        check("R4", "word pos clamp", sum_o, 32'h7FFF_FFFF);
        apply(32'h8000_0000, 32'hFFFF_FFFF, 2'b10, 1'b1, 1'b1);
        check("R4", "word neg clamp", sum_o, 32'h8000_0000);
        apply(32'h7FFF_FFFF, 32'h8000_0000, 2'b10, 1'b1, 1'b1);
        check("R4", "mixed signs no clamp", sum_o, 32'hFFFF_FFFF);
    endtask

    task automatic t_sign_ignored();
        logic [31:0] unsigned_res;
        apply(32'h7F80_FF01, 32'h0180_01FF, 2'b00, 1'b0, 1'b0);
        unsigned_res = sum_o;
        apply(32'h7F80_FF01, 32'h0180_01FF, 2'b00, 1'b1, 1'b0);
        check("R5", "signedness in wrap mode", sum_o, unsigned_res);
        check("R5", "signed wrap value", sum_o, 32'h8000_0000);
    endtask

    task automatic t_latency();
        apply(32'h0000_0010, 32'h0000_0020, 2'b10, 1'b0, 1'b0);
        @(negedge clk);
        opnd_a = 32'h0000_1000; opnd_b = 32'h0000_2000;
        #2;
        check("R8", "holds before edge", sum_o, 32'h0000_0030);
        @(negedge clk);
        check("R8", "updates after edge", sum_o, 32'h0000_3000);
    endtask

    task automatic t_sweep();
        logic [31:0] x = 32'h1234_5678;
        logic [31:0] va, vb;
        for (int n = 0; n < 240; n++) begin
            x = x ^ (x << 13); x = x ^ (x >> 17); x = x ^ (x << 5);
            va = x;
            x = x ^ (x << 13); x = x ^ (x >> 17); x = x ^ (x << 5);
            vb = (n % 3 == 0) ? (x | 32'h7F7F_7F7F) : x;
            case (n % 4)
                0: run_vec("R2", va, vb, 2'(n / 4), 1'(n / 16), 1'b0);
                1: run_vec("R3", va, vb, 2'(n / 4), 1'b0, 1'b1);
                2: run_vec("R4", va, vb, 2'(n / 4), 1'b1, 1'b1);
                default: run_vec("R6", va, vb, 2'(n / 4), 1'(n / 8), 1'b0);
            endcase
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        t_wrap_layouts();
        t_mode_codes();
        t_unsigned_sat();
        t_signed_sat();
        t_sign_ignored();
        t_latency();
        t_sweep();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule